// File: doc/BRIEF.md
# Chainable Multi-Channel PWM Generator

This block produces four pulse-width-modulated outputs from one shared time base. A prescaler divides the block clock. Each prescaler terminal tick moves a period counter up by one, from zero to a programmable top value, and then the counter wraps to zero. Each channel has its own switch-on count and switch-off count. The output is high while the counter lies in the half-open window from the switch-on count up to, but not including, the switch-off count.

Software writes all timing values into shadow registers through a simple write port. The values become active only at a period wrap, and only when the transfer-enable input is high. The transfer-enable state is also passed on to a neighbouring instance, so that a chain of generators can switch configuration together.

A sync input restarts the period. A sync output pulses at a programmable counter value, which lets this instance lead the next one in a chain. Two capture inputs latch the counter value on a rising edge. A trap input forces every output low until software clears the trap. Sticky flags report a period wrap, each capture and a trap.

Top module: `sync_pwm`

## Requirements
- R1: While no sync is applied, the period counter advances by one exactly once every PRE+1 clocks. PRE is the active prescale value, written at address 0.
- R2: The counter runs from 0 up to the active period top value (address 1) and then wraps to 0. Every wrap sets irq_period. The flag stays set until a write to address 3 with bit 0 set.
- R3: Channel k drives pwm_out[k] high exactly when its switch-on count is less than or equal to cnt_out and cnt_out is less than its switch-off count. The switch-on count is at address 4+2k and the switch-off count at address 5+2k. If the switch-on count is equal to or greater than the switch-off count, the output stays low.
- R4: A write to any timing address changes no behaviour at the ports until a wrap occurs while xfer_en_in is high. A wrap while xfer_en_in is low leaves the previous values in force.
- R5: xfer_en_out equals xfer_en_in delayed by one clock.
- R6: sync_in high at a clock edge sets cnt_out and the prescaler to 0 at that edge. This restart does not set irq_period and does not transfer shadow values.
- R7: sync_out is high for exactly one clock. That clock is the one in which cnt_out has just been loaded with the active sync delay value (address 2). No pulse occurs while the counter only holds its value.
- R8: A rising edge on cap_in[k] passes through a two-flop synchronizer. From the third clock edge that samples the input high, cap_val slice k holds the counter value and irq_cap[k] is set. A write to address 3 with bit 1+k set clears that flag.
- R9: trap_in high at a clock edge sets irq_trap at that edge and holds all pwm_out bits low. The outputs stay low until a write to address 3 with bit 3 set clears the flag, and that clear takes effect only while trap_in is low.
- R10: After reset the counter, pwm_out, sync_out, xfer_en_out, cap_val and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_addr | input | ADDR_W | Write address (0 prescale, 1 period top, 2 sync delay, 3 flag clear, 4.. switch-on/switch-off counts) |
| wr_data | input | DATA_W | Write data |
| xfer_en_in | input | 1 | Permits shadow-to-active transfer at a wrap |
| xfer_en_out | output | 1 | Registered copy of xfer_en_in for the next instance |
| sync_in | input | 1 | Period restart request |
| sync_out | output | 1 | One-clock pulse at the programmed counter value |
| trap_in | input | 1 | Forces outputs inactive |
| cap_in | input | NCAP | Asynchronous capture event inputs |
| pwm_out | output | NCH | PWM channel outputs |
| cnt_out | output | CNT_W | Current period counter value |
| cap_val | output | NCAP*CNT_W | Captured counter values, channel k at slice k |
| irq_period | output | 1 | Sticky period-wrap flag |
| irq_cap | output | NCAP | Sticky capture flags |
| irq_trap | output | 1 | Sticky trap flag |

## Verification
The outputs are due at different times. pwm_out is a combinational function of registered state, so the bench compares it with the switch-on and switch-off window in the same half-cycle in which it reads cnt_out. Counter, sync, transfer and trap results are due one edge after the stimulus. Capture results are due three edges after the input rises. Every input is driven at a falling edge, and every output is sampled at the falling edge that follows the due rising edge. New configuration is expected only after irq_period shows a wrap that took place with xfer_en_in held high.

// File: rtl/sync_pwm_pkg.sv
// Package: shared address map and flag-clear bit layout for the PWM generator.
// Assumes: the write port carries one register per address.
package sync_pwm_pkg;
    localparam int A_PRE  = 0;   // prescale limit
    localparam int A_PER  = 1;   // period top value
    localparam int A_DLY  = 2;   // sync output delay
    localparam int A_CLR  = 3;   // write-one-to-clear of flags
    localparam int A_EDGE = 4;   // first switch-on address, pairs per channel

    localparam int CLR_PERIOD = 0;  // bit clearing the period flag
    localparam int CLR_CAP0   = 1;  // first capture flag bit

    // Address of a channel's switch-on (fall_sel=0) or switch-off (fall_sel=1) count.
    function automatic int edge_addr(input int ch, input bit fall_sel);
        return A_EDGE + 2 * ch + (fall_sel ? 1 : 0);
    endfunction
endpackage

// File: rtl/sync_pwm_regs.sv
// Module: shadow and active timing registers.
// What: takes writes into shadow copies and moves all of them to the active set
// in one step when load is high.
// Assumes: load is high only on a period wrap with transfer enabled.
module sync_pwm_regs
    import sync_pwm_pkg::*;
#(
    parameter int PRE_W  = 16,
    parameter int CNT_W  = 16,
    parameter int NCH    = 4,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic                        load,
    output logic [PRE_W-1:0]            act_pre,
    output logic [CNT_W-1:0]            act_per,
    output logic [CNT_W-1:0]            act_dly,
    output logic [CNT_W-1:0]            dly_nx,
    output logic [NCH-1:0][CNT_W-1:0]   act_on,
    output logic [NCH-1:0][CNT_W-1:0]   act_off
);
    logic [PRE_W-1:0]          sh_pre;
    logic [CNT_W-1:0]          sh_per;
    logic [CNT_W-1:0]          sh_dly;
    logic [NCH-1:0][CNT_W-1:0] sh_on;
    logic [NCH-1:0][CNT_W-1:0] sh_off;

    // Shadow capture of the shared timing registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_pre <= '0;
            sh_per <= '0;
            sh_dly <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(A_PRE)) sh_pre <= wr_data[PRE_W-1:0];
            if (wr_addr == ADDR_W'(A_PER)) sh_per <= wr_data[CNT_W-1:0];
            if (wr_addr == ADDR_W'(A_DLY)) sh_dly <= wr_data[CNT_W-1:0];
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // Shadow capture of one channel's switch-on and switch-off counts.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh_on[i]  <= '0;
                sh_off[i] <= '0;
            end else if (wr_en) begin
                if (wr_addr == ADDR_W'(edge_addr(i, 1'b0))) sh_on[i]  <= wr_data[CNT_W-1:0];
                if (wr_addr == ADDR_W'(edge_addr(i, 1'b1))) sh_off[i] <= wr_data[CNT_W-1:0];
            end
        end
    end

    // Transfer of the full shadow set into the active set at a permitted wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_pre <= '0;
            act_per <= '0;
            act_dly <= '0;
            act_on  <= '0;
            act_off <= '0;
        end else if (load) begin
            act_pre <= sh_pre;
            act_per <= sh_per;
            act_dly <= sh_dly;
            act_on  <= sh_on;
            act_off <= sh_off;
        end
    end

    // Sync delay value that will be in force after the coming edge.
    always_comb dly_nx = load ? sh_dly : act_dly;

    // Active values only move on load (R4).
    p_active_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(act_per) && $stable(act_pre) && $stable(act_on) && $stable(act_off)));
endmodule

// File: rtl/sync_pwm_timebase.sv
// Module: prescaler, period counter and sync handling.
// What: divides the clock by pre_lim+1, counts 0..per_lim, restarts on sync_in
// and pulses sync_out when the counter is loaded with the delay value.
// Assumes: per_lim and pre_lim change only at a wrap, when both counters restart.
module sync_pwm_timebase #(
    parameter int PRE_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] pre_lim,
    input  logic [CNT_W-1:0] per_lim,
    input  logic [CNT_W-1:0] dly_act,
    input  logic [CNT_W-1:0] dly_nx,
    input  logic             sync_in,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             sync_out
);
    logic [PRE_W-1:0] pre_cnt;
    logic             tick;
    logic             moved;
    logic [CNT_W-1:0] cnt_nx;

    // Next-state decode for the prescaler and the period counter.
    always_comb begin
        tick  = (pre_cnt >= pre_lim);
        moved = sync_in || tick;
        wrap  = tick && (cnt >= per_lim) && !sync_in;
        if (sync_in)   cnt_nx = '0;
        else if (wrap) cnt_nx = '0;
        else if (tick) cnt_nx = cnt + 1'b1;
        else           cnt_nx = cnt;
    end

    // Counter registers and the sync pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt  <= '0;
            cnt      <= '0;
            sync_out <= 1'b0;
        end else begin
            pre_cnt  <= moved ? '0 : pre_cnt + 1'b1;
            cnt      <= cnt_nx;
            sync_out <= moved && (cnt_nx == dly_nx);
        end
    end

    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= per_lim);
    p_hold_between_ticks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !sync_in) |=> $stable(cnt));
    p_sync_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sync_in |=> (cnt == '0));
    p_sync_out_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out |-> (cnt == dly_act));
endmodule

// File: rtl/sync_pwm_channel.sv
// Module: one PWM output channel.
// What: drives the output high inside the window [on_cnt, off_cnt) of the counter,
// and low whenever kill is high.
// Assumes: all inputs are registered, so the output is glitch-limited to one level.
module sync_pwm_channel #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] on_cnt,
    input  logic [CNT_W-1:0] off_cnt,
    input  logic             kill,
    output logic             pwm
);
    // Window compare with trap override.
    always_comb pwm = !kill && (cnt >= on_cnt) && (cnt < off_cnt);
endmodule

// File: rtl/sync_pwm_capture.sv
// Module: one capture input.
// What: synchronizes an asynchronous event with two flops, detects its rising
// edge, latches the counter and sets a sticky flag.
// Assumes: an event lasts at least two clocks.
module sync_pwm_capture #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_async,
    input  logic [CNT_W-1:0] cnt,
    input  logic             clr,
    output logic [CNT_W-1:0] cap_val,
    output logic             flag
);
    logic s1, s2, s3;
    logic edge_seen;

    // Two-flop synchronizer plus history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= cap_async;
            s2 <= s1;
            s3 <= s2;
        end
    end

    always_comb edge_seen = s2 && !s3;

    // Latch the counter and set the flag on a detected edge; the clear loses to the set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_val <= '0;
            flag    <= 1'b0;
        end else begin
            if (edge_seen) cap_val <= cnt;
            if (edge_seen)  flag <= 1'b1;
            else if (clr)   flag <= 1'b0;
        end
    end

    p_capture_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        edge_seen |=> (flag && (cap_val == $past(cnt))));
endmodule

// File: rtl/sync_pwm.sv
// Module: top of the chainable multi-channel PWM generator.
// What: ties the register set, the time base, the channels and the capture
// units together, and keeps the period and trap flags and the transfer-enable relay.
// Assumes: PRE_W and CNT_W are no wider than DATA_W, and ADDR_W covers 4+2*NCH addresses.
module sync_pwm
    import sync_pwm_pkg::*;
#(
    parameter int PRE_W  = 16,
    parameter int CNT_W  = 16,
    parameter int NCH    = 4,
    parameter int NCAP   = 2,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   xfer_en_in,
    output logic                   xfer_en_out,
    input  logic                   sync_in,
    output logic                   sync_out,
    input  logic                   trap_in,
    input  logic [NCAP-1:0]        cap_in,
    output logic [NCH-1:0]         pwm_out,
    output logic [CNT_W-1:0]       cnt_out,
    output logic [NCAP*CNT_W-1:0]  cap_val,
    output logic                   irq_period,
    output logic [NCAP-1:0]        irq_cap,
    output logic                   irq_trap
);
    localparam int CLR_TRAP = CLR_CAP0 + NCAP;

    logic [PRE_W-1:0]          act_pre;
    logic [CNT_W-1:0]          act_per;
    logic [CNT_W-1:0]          act_dly;
    logic [CNT_W-1:0]          dly_nx;
    logic [NCH-1:0][CNT_W-1:0] act_on;
    logic [NCH-1:0][CNT_W-1:0] act_off;
    logic                      wrap;
    logic                      load;
    logic                      clr_wr;
    logic                      trap_q;

    always_comb begin
        load   = wrap && xfer_en_in;
        clr_wr = wr_en && (wr_addr == ADDR_W'(A_CLR));
    end

    sync_pwm_regs #(
        .PRE_W(PRE_W), .CNT_W(CNT_W), .NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .load(load), .act_pre(act_pre), .act_per(act_per), .act_dly(act_dly),
        .dly_nx(dly_nx), .act_on(act_on), .act_off(act_off)
    );

    sync_pwm_timebase #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .pre_lim(act_pre), .per_lim(act_per),
        .dly_act(act_dly), .dly_nx(dly_nx), .sync_in(sync_in),
        .cnt(cnt_out), .wrap(wrap), .sync_out(sync_out)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_pwm
        sync_pwm_channel #(.CNT_W(CNT_W)) u_ch (
            .cnt(cnt_out), .on_cnt(act_on[i]), .off_cnt(act_off[i]),
            .kill(trap_q), .pwm(pwm_out[i])
        );
    end

    for (genvar k = 0; k < NCAP; k++) begin : g_cap
        sync_pwm_capture #(.CNT_W(CNT_W)) u_cap (
            .clk(clk), .rst_n(rst_n), .cap_async(cap_in[k]), .cnt(cnt_out),
            .clr(clr_wr && wr_data[CLR_CAP0 + k]),
            .cap_val(cap_val[k*CNT_W +: CNT_W]), .flag(irq_cap[k])
        );
    end

    // Sticky period and trap flags with write-one-to-clear; set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_period <= 1'b0;
            trap_q     <= 1'b0;
        end else begin
            if (wrap)                                 irq_period <= 1'b1;
            else if (clr_wr && wr_data[CLR_PERIOD])   irq_period <= 1'b0;
            if (trap_in)                              trap_q <= 1'b1;
            else if (clr_wr && wr_data[CLR_TRAP])     trap_q <= 1'b0;
        end
    end

    // One-clock relay of the transfer enable to the next instance.
    always_ff @(posedge clk) begin
        if (!rst_n) xfer_en_out <= 1'b0;
        else        xfer_en_out <= xfer_en_in;
    end

    always_comb irq_trap = trap_q;

    p_trap_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_q |-> (pwm_out == '0));
    p_trap_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_in |=> irq_trap);
    p_xfer_relay_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (xfer_en_out == $past(xfer_en_in)));
    p_wrap_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> irq_period);
endmodule

// File: tb/sync_pwm_tb.sv
module sync_pwm_tb;
    localparam int NCH = 4;
    localparam int NCAP = 2;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic xfer_en_in = 1'b0;
    logic xfer_en_out;
    logic sync_in = 1'b0;
    logic sync_out;
    logic trap_in = 1'b0;
    logic [NCAP-1:0] cap_in = '0;
    logic [NCH-1:0] pwm_out;
    logic [CW-1:0] cnt_out;
    logic [NCAP*CW-1:0] cap_val;
    logic irq_period;
    logic [NCAP-1:0] irq_cap;
    logic irq_trap;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int exp_on [NCH];
    int exp_off[NCH];

    // Switch-on/switch-off table: byte k = channel k, high nibble switch-on, low nibble switch-off.
    localparam logic [31:0] VEC [3] = '{32'h7355_0A26, 32'h8934_9F01, 32'h6C00_1849};

    sync_pwm u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .xfer_en_in(xfer_en_in), .xfer_en_out(xfer_en_out), .sync_in(sync_in),
        .sync_out(sync_out), .trap_in(trap_in), .cap_in(cap_in), .pwm_out(pwm_out),
        .cnt_out(cnt_out), .cap_val(cap_val), .irq_period(irq_period),
        .irq_cap(irq_cap), .irq_trap(irq_trap)
    );

    always #10 clk = ~clk;

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Enable transfer, clear the period flag, wait for a wrap, and commit the model.
    task automatic apply_cfg(input int on_v[NCH], input int off_v[NCH]);
        xfer_en_in = 1'b1;
        @(negedge clk);
        wr(3, 1);
        for (int n = 0; n < 3000 && !irq_period; n++) @(negedge clk);
        xfer_en_in = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            exp_on[i] = on_v[i];
            exp_off[i] = off_v[i];
        end
    endtask

    function automatic logic [NCH-1:0] model_pwm(input int c);
        logic [NCH-1:0] r;
        for (int i = 0; i < NCH; i++) r[i] = (c >= exp_on[i]) && (c < exp_off[i]);
        return r;
    endfunction

    task automatic check_window(input int n, input string req);
        for (int s = 0; s < n; s++) begin
            chk(pwm_out == model_pwm(int'(cnt_out)), req, int'(pwm_out), int'(model_pwm(int'(cnt_out))));
            @(negedge clk);
        end
    endtask

    initial begin
        int on_v[NCH];
        int off_v[NCH];
        int prev;
        int n;
        int pulses;
        for (int i = 0; i < NCH; i++) begin exp_on[i] = 0; exp_off[i] = 0; end
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(cnt_out == 0 && pwm_out == 0 && sync_out == 0, "R10 outputs", int'(cnt_out), 0);
        chk(irq_period == 0 && irq_cap == 0 && irq_trap == 0 && xfer_en_out == 0 && cap_val == 0,
            "R10 flags", int'(irq_period), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: transfer-enable relay
        xfer_en_in = 1'b1;
        chk(xfer_en_out == 1'b0, "R5 before edge", int'(xfer_en_out), 0);
        @(negedge clk);
        chk(xfer_en_out == 1'b1, "R5 rise", int'(xfer_en_out), 1);
        xfer_en_in = 1'b0;
        @(negedge clk);
        chk(xfer_en_out == 1'b0, "R5 fall", int'(xfer_en_out), 0);

        // R3: table walk, period top 9, prescale 1
        wr(0, 1); wr(1, 9);
        foreach (VEC[e]) begin
            for (int i = 0; i < NCH; i++) begin
                on_v[i]  = int'(VEC[e][8*i+4 +: 4]);
                off_v[i] = int'(VEC[e][8*i +: 4]);
                wr(4 + 2*i, on_v[i]);
                wr(5 + 2*i, off_v[i]);
            end
            apply_cfg(on_v, off_v);
            check_window(40, "R3 window");
        end

        // R4: shadow write without transfer leaves channel 0 unchanged
        wr(4, 0); wr(5, 10);
        @(negedge clk); wr(3, 1);
        for (int k = 0; k < 100 && !irq_period; k++) @(negedge clk);
        chk(irq_period == 1'b1, "R4 wrap seen", int'(irq_period), 1);
        check_window(40, "R4 no transfer");
        for (int i = 0; i < NCH; i++) begin on_v[i] = exp_on[i]; off_v[i] = exp_off[i]; end
        on_v[0] = 0; off_v[0] = 10;
        apply_cfg(on_v, off_v);
        check_window(40, "R4 after transfer");

        // R9: trap forces outputs low until cleared while trap_in is low
        chk(pwm_out[0] == 1'b1, "R9 pre-trap", int'(pwm_out[0]), 1);
        trap_in = 1'b1;
        @(negedge clk);
        chk(pwm_out == 0 && irq_trap == 1'b1, "R9 trap", int'(pwm_out), 0);
        wr(3, 8);
        chk(irq_trap == 1'b1, "R9 clear blocked", int'(irq_trap), 1);
        trap_in = 1'b0;
        repeat (5) @(negedge clk);
        chk(pwm_out == 0, "R9 stays low", int'(pwm_out), 0);
        wr(3, 8);
        chk(irq_trap == 1'b0 && pwm_out[0] == 1'b1, "R9 cleared", int'(pwm_out[0]), 1);

        // R2: period 4, prescale 0 sequence and sticky flag
        wr(0, 0); wr(1, 4);
        apply_cfg(on_v, off_v);
        for (int k = 0; k < 12; k++) begin
            prev = int'(cnt_out);
            @(negedge clk);
            chk(int'(cnt_out) == ((prev == 4) ? 0 : prev + 1), "R2 sequence", int'(cnt_out),
                (prev == 4) ? 0 : prev + 1);
        end
        chk(irq_period == 1'b1, "R2 flag", int'(irq_period), 1);

        // R1: prescale 3 gives a step every 4 clocks
        wr(0, 3); wr(1, 9); wr(2, 3);
        apply_cfg(on_v, off_v);
        prev = int'(cnt_out);
        for (int k = 0; k < 10 && int'(cnt_out) == prev; k++) @(negedge clk);
        prev = int'(cnt_out);
        n = 0;
        for (int k = 0; k < 10 && int'(cnt_out) == prev; k++) begin @(negedge clk); n++; end
        chk(n == 4, "R1 step interval", n, 4);

        // R7: sync delay 3, prescale 7; one pulse per 80-clock period
        wr(0, 7);
        apply_cfg(on_v, off_v);
        pulses = 0;
        for (int k = 0; k < 90; k++) begin
            if (sync_out) begin
                pulses++;
                chk(int'(cnt_out) == 3, "R7 pulse value", int'(cnt_out), 3);
            end
            @(negedge clk);
        end
        chk(pulses == 1, "R7 pulse count", pulses, 1);

        // R6: sync restart from count 5, no period flag
        wr(3, 1);
        chk(irq_period == 1'b0, "R2 clear", int'(irq_period), 0);
        for (int k = 0; k < 200 && int'(cnt_out) != 5; k++) @(negedge clk);
        sync_in = 1'b1;
        @(negedge clk);
        sync_in = 1'b0;
        chk(cnt_out == 0, "R6 restart", int'(cnt_out), 0);
        chk(irq_period == 1'b0, "R6 no flag", int'(irq_period), 0);

        // R8: capture on input 1 while counter holds 1
        wr(0, 200);
        apply_cfg(on_v, off_v);
        for (int k = 0; k < 400 && int'(cnt_out) != 1; k++) @(negedge clk);
        cap_in[1] = 1'b1;
        @(negedge clk);
        chk(irq_cap == 0, "R8 edge 1", int'(irq_cap), 0);
        @(negedge clk);
        chk(irq_cap == 0, "R8 edge 2", int'(irq_cap), 0);
        @(negedge clk);
        chk(irq_cap == 2'b10, "R8 flag", int'(irq_cap), 2);
        chk(int'(cap_val[CW +: CW]) == 1, "R8 value", int'(cap_val[CW +: CW]), 1);
        cap_in[1] = 1'b0;
        wr(3, 4);
        chk(irq_cap == 0, "R8 clear", int'(irq_cap), 0);

        summary();
        $finish;
    end
endmodule